// File: doc/BRIEF.md
# Result Collector Arbitration Tree

This block gathers results from many producers into a single output queue. Every producer writes into its own small leaf FIFO. Above the leaves sit layers of collector nodes. Each node owns one FIFO and a round-robin arbiter, and moves one result per cycle from one of its child FIFOs into that FIFO. The number of children per node (four by default) and the number of layers are parameters. The leaf count equals fan-in raised to the number of layers. The FIFO of the single top node is the output queue.

A child FIFO whose fill level reaches its almost-full threshold is served ahead of every child that only has data waiting. A node whose own FIFO is full stops granting, so congestion travels from the output back to the leaves. Once any leaf FIFO is full, the block raises a global stall. While the stall is high, every producer must hold its result, so no result is ever dropped.

Top module: `rc_tree`

## Requirements
- R1: While reset is low and in the first cycle after it, `out_valid` and `stall` are 0.
- R2: Every result accepted at a leaf leaves the output exactly once. Results from one producer leave in the order they were accepted.
- R3: A result accepted at a leaf of an empty tree at clock edge E appears on `out_valid`/`out_data` right after edge E+LEVELS (one cycle per node layer).
- R4: A node grants only children whose FIFO is non-empty. Among plain requesters it searches in round-robin order, starting at the child just past the last winner; this pointer moves only on a grant and is 0 after reset.
- R5: A child FIFO holding at least its almost-full threshold of entries (default 3 of 4) raises an urgent request. Urgent requests win over plain ones, and several urgent requests share the same round-robin pointer.
- R6: A node whose own FIFO is full grants no child in that cycle, and no FIFO is ever written while full.
- R7: `stall` is 1 exactly when at least one leaf FIFO is full. While `stall` is 1, `in_valid` is ignored at every leaf.
- R8: `out_valid` is 1 while the output FIFO holds data. A result is removed on a clock edge with `out_valid` and `out_ready` both high. Otherwise `out_data` holds its value.
- R9: Each node moves at most one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | FANIN**LEVELS | Per-producer write request |
| in_data | input | FANIN**LEVELS*DATA_W | Per-producer result; producer i at bits [i*DATA_W +: DATA_W] |
| stall | output | 1 | Some leaf FIFO is full; producers must hold |
| out_valid | output | 1 | Output FIFO is non-empty |
| out_data | output | DATA_W | Oldest result in the output FIFO |
| out_ready | input | 1 | Consumer takes the head result |

## Verification
The FIFO overflow assertion relies on producers asserting `in_valid` only when they are allowed to. The block itself gates writes by `stall`, so every bench stimulus is legal, including pushes deliberately driven while `stall` is high. The output hold property assumes the consumer keeps `out_ready` meaningful only while `out_valid` is high. The bench samples `out_valid` at the negative edge and counts a removal only when it also drives `out_ready`. Random traffic mixes sparse and dense producer activity with a consumer that randomly withholds `out_ready`. This fills nodes enough to reach urgent requests and the global stall. Directed sequences on separate subtrees pin down the exact grant order.

// File: rtl/rc_pkg.sv
// Package: shared constant functions for sizing the collector tree.
// Assumes fan-in >= 2 and small level counts (elaboration-time only).
package rc_pkg;

    // Integer power, used for node counts per level.
    function automatic int ipow(input int base, input int ex);
        int acc;
        acc = 1;
        for (int k = 0; k < ex; k++) acc = acc * base;
        return acc;
    endfunction

    // Flat FIFO index of the first FIFO of level lvl (0 = leaves).
    function automatic int lvl_off(input int fan, input int levels, input int lvl);
        int acc;
        acc = 0;
        for (int k = 0; k < lvl; k++) acc = acc + ipow(fan, levels - k);
        return acc;
    endfunction

endpackage

// File: rtl/rc_fifo.sv
// Module: synchronous FIFO with full, empty and almost-full flags.
// The head entry is visible on rdata without a read. Writes when full
// and reads when empty are ignored. Assumes AF_LEVEL <= DEPTH.
module rc_fifo #(
    parameter int W        = 16,
    parameter int DEPTH    = 4,
    parameter int AF_LEVEL = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full,
    output logic         afull
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write, no reset needed.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    assign rdata = mem[rd_ptr];
    assign empty = (count == '0);
    assign full  = (count == CW'(DEPTH));
    assign afull = (count >= CW'(AF_LEVEL));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full))
        else $error("FIFO written while full");

    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(pop && empty))
        else $error("FIFO read while empty");

    p_count_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> !empty)
        else $error("FIFO empty right after a write");

endmodule

// File: rtl/rc_rr_arbiter.sv
// Module: two-level round-robin arbiter. Urgent requests (urg) are
// served before plain ones (req). Both levels share one pointer that
// starts at the requester just past the last winner.
// Assumes urg implies req.
module rc_rr_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    input  logic [N-1:0] urg,
    output logic [N-1:0] grant
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] ptr;
    logic [IW-1:0] win;
    logic [N-1:0]  cand;
    logic          found;

    // Pick candidate set, then search from the pointer.
    always_comb begin
        cand  = en ? ((|(urg & req)) ? (urg & req) : req) : '0;
        grant = '0;
        win   = '0;
        found = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (int'(ptr) + k) % N;
            if (!found && cand[idx]) begin
                found      = 1'b1;
                grant[idx] = 1'b1;
                win        = IW'(idx);
            end
        end
    end

    // Pointer moves past the winner only on a grant.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else if (found) ptr <= (win == IW'(N - 1)) ? '0 : win + 1'b1;
    end

    p_grant_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("more than one grant");

    p_grant_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0)
        else $error("grant to idle requester");

    p_urgent_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && |(urg & req)) |-> |(grant & urg))
        else $error("plain request beat an urgent one");

    p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (grant == '0))
        else $error("grant while disabled");

endmodule

// File: rtl/rc_node.sv
// Module: one collector node. Arbitrates among FANIN child FIFOs and
// moves the winner's head entry into the node's own FIFO in the same
// cycle. Stops granting while the own FIFO is full.
module rc_node #(
    parameter int FANIN  = 4,
    parameter int DATA_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [FANIN-1:0]        ch_empty,
    input  logic [FANIN-1:0]        ch_afull,
    input  logic [FANIN*DATA_W-1:0] ch_data,
    output logic [FANIN-1:0]        ch_pop,
    input  logic                    own_full,
    output logic                    own_push,
    output logic [DATA_W-1:0]       own_data
);
    logic [FANIN-1:0] grant;

    rc_rr_arbiter #(.N(FANIN)) i_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (!own_full),
        .req   (~ch_empty),
        .urg   (ch_afull),
        .grant (grant)
    );

    // Select the granted child's head entry.
    always_comb begin
        own_data = '0;
        for (int c = 0; c < FANIN; c++) begin
            if (grant[c]) own_data = ch_data[c*DATA_W +: DATA_W];
        end
    end

    assign ch_pop   = grant;
    assign own_push = |grant;

    p_no_push_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
        own_full |-> !own_push)
        else $error("node wrote into its full FIFO");

    p_pop_from_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_pop & ch_empty) == '0)
        else $error("node popped an empty child");

endmodule

// File: rtl/rc_tree.sv
// Module: top of the result collector. FANIN**LEVELS leaf FIFOs feed
// LEVELS layers of collector nodes; the top node's FIFO is the output.
// Assumes producers hold their data while stall is high (their writes
// are ignored then).
module rc_tree
    import rc_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int FANIN      = 4,
    parameter int LEVELS     = 2,
    parameter int LEAF_DEPTH = 4,
    parameter int LEAF_AF    = 3,
    parameter int NODE_DEPTH = 4,
    parameter int NODE_AF    = 3,
    localparam int N_LEAVES  = ipow(FANIN, LEVELS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_LEAVES-1:0]        in_valid,
    input  logic [N_LEAVES*DATA_W-1:0] in_data,
    output logic                       stall,
    output logic                       out_valid,
    output logic [DATA_W-1:0]          out_data,
    input  logic                       out_ready
);
    localparam int TOTAL = lvl_off(FANIN, LEVELS, LEVELS + 1);
    localparam int ROOT  = TOTAL - 1;

    logic              f_push  [TOTAL];
    logic              f_pop   [TOTAL];
    logic              f_empty [TOTAL];
    logic              f_full  [TOTAL];
    logic              f_afull [TOTAL];
    logic [DATA_W-1:0] f_wdata [TOTAL];
    logic [DATA_W-1:0] f_rdata [TOTAL];

    // Global stall: any leaf FIFO full.
    always_comb begin
        stall = 1'b0;
        for (int i = 0; i < N_LEAVES; i++) stall = stall | f_full[i];
    end

    genvar i, l, j, c;
    generate
        for (i = 0; i < N_LEAVES; i++) begin : g_leaf
            assign f_push[i]  = in_valid[i] && !stall;
            assign f_wdata[i] = in_data[i*DATA_W +: DATA_W];
            rc_fifo #(.W(DATA_W), .DEPTH(LEAF_DEPTH), .AF_LEVEL(LEAF_AF)) i_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (f_push[i]),
                .wdata (f_wdata[i]),
                .pop   (f_pop[i]),
                .rdata (f_rdata[i]),
                .empty (f_empty[i]),
                .full  (f_full[i]),
                .afull (f_afull[i])
            );
        end

        for (l = 1; l <= LEVELS; l++) begin : g_lvl
            for (j = 0; j < ipow(FANIN, LEVELS - l); j++) begin : g_node
                localparam int SELF  = lvl_off(FANIN, LEVELS, l) + j;
                localparam int CBASE = lvl_off(FANIN, LEVELS, l - 1) + j * FANIN;

                logic [FANIN-1:0]        c_empty, c_afull, c_pop;
                logic [FANIN*DATA_W-1:0] c_data;

                for (c = 0; c < FANIN; c++) begin : g_ch
                    assign c_empty[c]                  = f_empty[CBASE + c];
                    assign c_afull[c]                  = f_afull[CBASE + c];
                    assign c_data[c*DATA_W +: DATA_W]  = f_rdata[CBASE + c];
                    assign f_pop[CBASE + c]            = c_pop[c];
                end

                rc_node #(.FANIN(FANIN), .DATA_W(DATA_W)) i_node (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .ch_empty (c_empty),
                    .ch_afull (c_afull),
                    .ch_data  (c_data),
                    .ch_pop   (c_pop),
                    .own_full (f_full[SELF]),
                    .own_push (f_push[SELF]),
                    .own_data (f_wdata[SELF])
                );

                rc_fifo #(.W(DATA_W), .DEPTH(NODE_DEPTH), .AF_LEVEL(NODE_AF)) i_fifo (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .push  (f_push[SELF]),
                    .wdata (f_wdata[SELF]),
                    .pop   (f_pop[SELF]),
                    .rdata (f_rdata[SELF]),
                    .empty (f_empty[SELF]),
                    .full  (f_full[SELF]),
                    .afull (f_afull[SELF])
                );
            end
        end
    endgenerate

    assign f_pop[ROOT] = out_ready && !f_empty[ROOT];
    assign out_valid   = !f_empty[ROOT];
    assign out_data    = f_rdata[ROOT];

    p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
        else $error("output changed without being taken");

    p_root_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        f_full[ROOT] |-> (f_afull[ROOT] && out_valid))
        else $error("output FIFO flags inconsistent");

endmodule

// File: tb/test_rc_tree.sv
// Bench: directed grant-order cases plus seeded random traffic, checked
// against a per-producer sequence scoreboard.
module test_rc_tree;
    localparam int W  = 16;
    localparam int NL = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NL-1:0]   in_valid = '0;
    logic [NL*W-1:0] in_data = '0;
    logic            stall;
    logic            out_valid;
    logic [W-1:0]    out_data;
    logic            out_ready = 1'b0;

    int checks = 0;
    int errors = 0;
    int seq_in  [NL];
    int seq_out [NL];
    int pop_log [$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rc_tree i_rc_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .stall     (stall),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_ready (out_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Scoreboard for one removed result: leaf id in [15:12], sequence in [11:0].
    task automatic take(input logic [W-1:0] d);
        int leaf;
        leaf = int'(d[15:12]);
        pop_log.push_back(leaf);
        check(int'(d[11:0]) == (seq_out[leaf] & 12'hFFF), "R2", int'(d[11:0]), seq_out[leaf]);
        seq_out[leaf]++;
    endtask

    // One clock: drive at negedge, account at negedge, advance.
    task automatic step(input logic [NL-1:0] v, input logic r);
        in_valid  = v;
        out_ready = r;
        for (int k = 0; k < NL; k++)
            in_data[k*W +: W] = {4'(k), 12'(seq_in[k])};
        if (out_valid && r) take(out_data);
        for (int k = 0; k < NL; k++)
            if (v[k] && !stall) seq_in[k]++;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int k = 0; k < NL; k++) begin
            seq_in[k]  = 0;
            seq_out[k] = 0;
        end
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
        check(stall == 1'b0, "R1 stall in reset", stall, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0 && stall == 1'b0, "R1 after reset", {out_valid, stall}, 0);

        // R3: latency through two layers.
        step(16'h0001, 1'b1);
        check(out_valid == 1'b0, "R3 edge E", out_valid, 0);
        step('0, 1'b1);
        check(out_valid == 1'b0, "R3 edge E+1", out_valid, 0);
        step('0, 1'b1);
        check(out_valid == 1'b1, "R3 edge E+2 valid", out_valid, 1);
        check(out_data == 16'h0000, "R3 edge E+2 data", out_data, 0);
        repeat (4) step('0, 1'b1);

        // R4: round-robin among leaves 4..7 from pointer 0.
        pop_log.delete();
        step(16'h00F0, 1'b1);
        step(16'h00F0, 1'b1);
        repeat (12) step('0, 1'b1);
        check(pop_log.size() == 8, "R4 count", pop_log.size(), 8);
        for (int k = 0; k < 8 && k < pop_log.size(); k++)
            check(pop_log[k] == 4 + (k % 4), "R4 order", pop_log[k], 4 + (k % 4));

        // R5/R6: back up node 2, then urgent leaf 9 beats leaf 11.
        repeat (8) step(16'h0400, 1'b0);
        repeat (6) step('0, 1'b0);
        step(16'h0A00, 1'b0);
        step(16'h0200, 1'b0);
        step(16'h0200, 1'b0);
        check(stall == 1'b0, "R7 no leaf full", stall, 0);
        check(out_valid == 1'b1, "R6 output held", out_valid, 1);
        pop_log.delete();
        repeat (24) step('0, 1'b1);
        check(pop_log.size() == 12, "R6 count", pop_log.size(), 12);
        if (pop_log.size() == 12) begin
            for (int k = 0; k < 8; k++)
                check(pop_log[k] == 10, "R6 backlog first", pop_log[k], 10);
            check(pop_log[8] == 9, "R5 urgent first", pop_log[8], 9);
            check(pop_log[9] == 11, "R4 pointer past winner", pop_log[9], 11);
            check(pop_log[10] == 9 && pop_log[11] == 9, "R4 tail", pop_log[10], 9);
        end

        // R7: fill leaf 12 path, stall rises, writes ignored.
        repeat (12) step(16'h1000, 1'b0);
        repeat (6) step('0, 1'b0);
        check(stall == 1'b1, "R7 stall raised", stall, 1);
        check(seq_in[12] == 12, "R7 all accepted before stall", seq_in[12], 12);
        step(16'h1001, 1'b0);
        check(out_data == 16'hC000, "R8 head held", out_data, 16'hC000);
        pop_log.delete();
        repeat (30) step('0, 1'b1);
        check(pop_log.size() == 12, "R7 ignored during stall", pop_log.size(), 12);
        check(stall == 1'b0, "R7 stall cleared", stall, 0);
        check(out_valid == 1'b0, "R8 empty after drain", out_valid, 0);

        // Random traffic.
        for (int n = 0; n < 4000; n++) begin
            logic [NL-1:0] v;
            int dens;
            dens = (n < 2000) ? 25 : 70;
            for (int k = 0; k < NL; k++) v[k] = ($urandom % 100) < dens;
            step(v, ($urandom % 100) < 55);
        end
        repeat (300) step('0, 1'b1);
        for (int k = 0; k < NL; k++)
            check(seq_out[k] == seq_in[k], "R2 all delivered", seq_out[k], seq_in[k]);
        check(out_valid == 1'b0 && stall == 1'b0, "R8 idle at end", {out_valid, stall}, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule